// File: doc/BRIEF.md
# Cartridge Bank Switching Controller

This block is the address-mapping logic of an 8-bit console cartridge. The CPU writes bank numbers into a handful of control locations inside its 32 KB program window. The block keeps three writable program bank registers, eight pattern bank registers and a mirroring select. From these it forms program ROM and pattern ROM addresses. The program window is split into four 8 KB slots, and the last slot always maps the top bank. The video pattern space below 0x2000 is split into eight 1 KB slots.

Both translations are combinational in the current address and the register contents. Register writes land on the rising clock edge at which the write strobe is high. Bank numbers are trimmed to the fitted ROM size with a mask derived from parameters. Video addresses at or above 0x2000 are returned unchanged on the pattern address output.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, program slots 0, 1, 2 and 3 map banks 0x00, 0x01, 0xFE and 0xFF, each masked. Every pattern slot maps bank 0, and the mirroring output is 0 (vertical).
- R2: The program ROM address is {masked bank of slot cpu_addr[14:13], cpu_addr[12:0]}.
- R3: A write at offset 0x0000, 0x2000 or 0x4000 loads program slot 0, 1 or 2 respectively. The new value is visible in the cycle after the strobe edge.
- R4: Program slot 3 always maps bank 0xFF masked. No write changes it.
- R5: A program bank is ANDed with (PRG_SIZE_KB/8)−1, and a pattern bank is ANDed with CHR_SIZE_KB−1.
- R6: For a video address below 0x2000, the pattern ROM address is {masked bank of slot ppu_addr[12:10], ppu_addr[9:0]}.
- R7: A write at offset 0x3000+n, for n = 0 to 7, loads pattern slot n.
- R8: A write at offset 0x1001 sets the mirroring output to data bit 7: 0 is vertical, 1 is horizontal.
- R9: A write at any other offset, including 0x1000, 0x2001 and 0x3008, leaves every bank and mirroring output unchanged.
- R10: For a video address at or above 0x2000, the pattern ROM address equals the video address, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe inside the program window |
| wr_addr | input | 15 | Offset of the write within the window |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 15 | CPU read offset within the window |
| prg_rom_addr | output | PRG_AW | Program ROM address |
| ppu_addr | input | 14 | Video read address |
| chr_rom_addr | output | CHR_AW | Pattern ROM address (PPU address when not translated) |
| mirror_horiz | output | 1 | 1 selects horizontal mirroring, 0 selects vertical |

## Verification
A wrong bank register shows as a wrong upper field on the ROM address output. This appears in the first read of the affected slot after the write edge, so every slot is read right after each write and again after writes meant to be ignored. A decode fault that accepts a neighbouring offset would corrupt a slot silently. For that reason, near-miss offsets are followed by a full sweep of all slots and the mirroring output. The mask is seen whenever a bank value larger than the fitted ROM is written: the upper bits must come back cleared.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
    localparam int WIN_AW  = 15;
    localparam int PPU_AW  = 14;
    localparam int NPRG    = 4;
    localparam int NCHR    = 8;

    typedef logic [7:0] bank_t;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_PRG,
        WK_CHR,
        WK_MIRROR
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e   kind;
        logic [2:0] idx;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic [WIN_AW-1:0] a);
        wr_dec_t d;
        d.kind = WK_NONE;
        d.idx  = 3'd0;
        if (a == 15'h0000) begin
            d.kind = WK_PRG;
            d.idx = 3'd0;
        end else if (a == 15'h2000) begin
            d.kind = WK_PRG;
            d.idx = 3'd1;
        end else if (a == 15'h4000) begin
            d.kind = WK_PRG;
            d.idx = 3'd2;
        end else if (a == 15'h1001) begin
            d.kind = WK_MIRROR;
        end else if (a[14:3] == 12'h600) begin
            d.kind = WK_CHR;
            d.idx = a[2:0];
        end
        return d;
    endfunction

    function automatic bank_t prg_reset_bank(input int slot);
        case (slot)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
    import cart_bank_pkg::*;
(
    input  logic              wr_en,
    input  logic [WIN_AW-1:0] wr_addr,
    output logic [NPRG-2:0]   prg_we,
    output logic [NCHR-1:0]   chr_we,
    output logic              mir_we
);
    wr_dec_t dec;

    always_comb begin
        dec = decode_write(wr_addr);
        prg_we = '0;
        chr_we = '0;
        mir_we = 1'b0;
        if (wr_en) begin
            unique case (dec.kind)
                WK_PRG: prg_we[dec.idx[1:0]] = 1'b1;
                WK_CHR: chr_we[dec.idx] = 1'b1;
                WK_MIRROR: mir_we = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        assert ($countones({prg_we, chr_we, mir_we}) <= 1)
            else $error("AST_ONE_TARGET"); // R9
    end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPRG-2:0] prg_we,
    input  logic [NCHR-1:0] chr_we,
    input  logic            mir_we,
    input  bank_t           wr_data,
    output bank_t           prg_bank [NPRG],
    output bank_t           chr_bank [NCHR],
    output logic            mirror_horiz
);
    genvar g;
    generate
        for (g = 0; g < NPRG - 1; g++) begin : g_prg
            always_ff @(posedge clk) begin
                if (rst) prg_bank[g] <= prg_reset_bank(g);
                else if (prg_we[g]) prg_bank[g] <= wr_data;
            end
            AST_PRG_HOLD: assert property (@(posedge clk) disable iff (rst)
                !prg_we[g] |=> $stable(prg_bank[g])); // R9
        end
        for (g = 0; g < NCHR; g++) begin : g_chr
            always_ff @(posedge clk) begin
                if (rst) chr_bank[g] <= '0;
                else if (chr_we[g]) chr_bank[g] <= wr_data;
            end
            AST_CHR_LOAD: assert property (@(posedge clk) disable iff (rst)
                chr_we[g] |=> chr_bank[g] == $past(wr_data)); // R7
        end
    endgenerate

    assign prg_bank[NPRG-1] = prg_reset_bank(NPRG - 1);

    always_ff @(posedge clk) begin
        if (rst) mirror_horiz <= 1'b0;
        else if (mir_we) mirror_horiz <= wr_data[7];
    end

    AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mir_we |=> $stable(mirror_horiz)); // R8
endmodule

// File: rtl/cart_addr_xlate.sv
module cart_addr_xlate
    import cart_bank_pkg::*;
#(
    parameter int PRG_SIZE_KB = 256,
    parameter int CHR_SIZE_KB = 256,
    localparam int PRG_BANKS = PRG_SIZE_KB / 8,
    localparam int CHR_BANKS = CHR_SIZE_KB,
    localparam int PRG_BW = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int CHR_BW = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int PRG_AW = PRG_BW + 13,
    localparam int CHR_AW = ((CHR_BW + 10) > PPU_AW) ? (CHR_BW + 10) : PPU_AW
)(
    input  logic [WIN_AW-1:0] cpu_addr,
    input  bank_t             prg_bank [NPRG],
    output logic [PRG_AW-1:0] prg_rom_addr,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  bank_t             chr_bank [NCHR],
    output logic [CHR_AW-1:0] chr_rom_addr
);
    localparam bank_t PRG_MASK = bank_t'(PRG_BANKS - 1);
    localparam bank_t CHR_MASK = bank_t'(CHR_BANKS - 1);

    bank_t pb, cb;

    always_comb begin
        pb = prg_bank[cpu_addr[14:13]] & PRG_MASK;
        prg_rom_addr = {pb[PRG_BW-1:0], cpu_addr[12:0]};
    end

    always_comb begin
        cb = chr_bank[ppu_addr[12:10]] & CHR_MASK;
        if (ppu_addr[13])
            chr_rom_addr = CHR_AW'(ppu_addr);
        else
            chr_rom_addr = CHR_AW'({cb[CHR_BW-1:0], ppu_addr[9:0]});
    end

    always_comb begin
        assert (prg_rom_addr[12:0] == cpu_addr[12:0]) else $error("AST_PRG_OFFSET"); // R2
        if (ppu_addr[13])
            assert (chr_rom_addr == CHR_AW'(ppu_addr)) else $error("AST_CHR_PASS"); // R10
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_bank_pkg::*;
#(
    parameter int PRG_SIZE_KB = 256,
    parameter int CHR_SIZE_KB = 256,
    localparam int PRG_BANKS = PRG_SIZE_KB / 8,
    localparam int PRG_BW = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int CHR_BW = (CHR_SIZE_KB > 1) ? $clog2(CHR_SIZE_KB) : 1,
    localparam int PRG_AW = PRG_BW + 13,
    localparam int CHR_AW = ((CHR_BW + 10) > 14) ? (CHR_BW + 10) : 14
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [14:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [14:0]       cpu_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    input  logic [13:0]       ppu_addr,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic              mirror_horiz
);
    logic [NPRG-2:0] prg_we;
    logic [NCHR-1:0] chr_we;
    logic            mir_we;
    bank_t           prg_bank [NPRG];
    bank_t           chr_bank [NCHR];

    cart_wr_decode u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr),
        .prg_we(prg_we), .chr_we(chr_we), .mir_we(mir_we)
    );

    cart_bank_regs u_regs (
        .clk(clk), .rst(rst),
        .prg_we(prg_we), .chr_we(chr_we), .mir_we(mir_we),
        .wr_data(wr_data),
        .prg_bank(prg_bank), .chr_bank(chr_bank),
        .mirror_horiz(mirror_horiz)
    );

    cart_addr_xlate #(.PRG_SIZE_KB(PRG_SIZE_KB), .CHR_SIZE_KB(CHR_SIZE_KB)) u_xlate (
        .cpu_addr(cpu_addr), .prg_bank(prg_bank), .prg_rom_addr(prg_rom_addr),
        .ppu_addr(ppu_addr), .chr_bank(chr_bank), .chr_rom_addr(chr_rom_addr)
    );

    AST_LAST_SLOT_FIXED: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[14:13] == 2'd3 |-> prg_rom_addr[PRG_AW-1:13] == {PRG_BW{1'b1}}); // R4
    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 15'h1001) |=> mirror_horiz == $past(wr_data[7])); // R8
    AST_PRG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 15'h2000) ##1 (cpu_addr[14:13] == 2'd1)
        |-> prg_rom_addr[PRG_AW-1:13] == PRG_BW'($past(wr_data))); // R3
endmodule

// File: tb/test_cart_bank_mapper.sv
module test_cart_bank_mapper;
    localparam int PRG_SIZE_KB = 256;
    localparam int CHR_SIZE_KB = 256;
    localparam int PRG_AW = 18;
    localparam int CHR_AW = 18;

    logic clk = 0, rst = 1, wr_en = 0;
    logic [14:0] wr_addr = '0, cpu_addr = '0;
    logic [7:0] wr_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [PRG_AW-1:0] prg_rom_addr;
    logic [CHR_AW-1:0] chr_rom_addr;
    logic mirror_horiz;

    int n_checks = 0, n_fail = 0;
    logic [7:0] exp_prg [4];
    logic [7:0] exp_chr [8];
    logic exp_mir;

    always #2 clk = ~clk;

    cart_bank_mapper #(.PRG_SIZE_KB(PRG_SIZE_KB), .CHR_SIZE_KB(CHR_SIZE_KB)) i_cart_bank_mapper (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .prg_rom_addr(prg_rom_addr), .ppu_addr(ppu_addr),
        .chr_rom_addr(chr_rom_addr), .mirror_horiz(mirror_horiz)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 4; s++) begin
            cpu_addr = {s[1:0], 13'h0A5C};
            #1;
            check(req, 32'(prg_rom_addr), 32'({exp_prg[s][4:0], 13'h0A5C}));
        end
        for (int s = 0; s < 8; s++) begin
            ppu_addr = {1'b0, s[2:0], 10'h2B3};
            #1;
            check(req, 32'(chr_rom_addr), 32'({exp_chr[s], 10'h2B3}));
        end
        check(req, 32'(mirror_horiz), 32'(exp_mir));
    endtask

    task automatic t_reset;
        exp_prg[0] = 8'h00; exp_prg[1] = 8'h01; exp_prg[2] = 8'hFE; exp_prg[3] = 8'hFF;
        for (int i = 0; i < 8; i++) exp_chr[i] = 8'h00;
        exp_mir = 0;
        sweep("R1");
    endtask

    task automatic t_prg_writes;
        wr(15'h0000, 8'h13); exp_prg[0] = 8'h13;
        wr(15'h2000, 8'h07); exp_prg[1] = 8'h07;
        wr(15'h4000, 8'hE5); exp_prg[2] = 8'hE5; // R5 masks to 0x05
        sweep("R3");
        cpu_addr = 15'h7FFF; #1;
        check("R2", 32'(prg_rom_addr), 32'h3FFFF);
    endtask

    task automatic t_slot3;
        wr(15'h6000, 8'h00);
        wr(15'h6001, 8'h22);
        cpu_addr = 15'h6123; #1;
        check("R4", 32'(prg_rom_addr), 32'({5'h1F, 13'h0123}));
    endtask

    task automatic t_chr_writes;
        for (int i = 0; i < 8; i++) begin
            wr(15'h3000 + 15'(i), 8'(8'h30 + i * 8'h11));
            exp_chr[i] = 8'(8'h30 + i * 8'h11);
        end
        sweep("R7");
        ppu_addr = 14'h1FFF; #1;
        check("R6", 32'(chr_rom_addr), 32'({exp_chr[7], 10'h3FF}));
    endtask

    task automatic t_mirror;
        wr(15'h1001, 8'h80); exp_mir = 1;
        #1 check("R8", 32'(mirror_horiz), 1);
        wr(15'h1001, 8'h7F); exp_mir = 0;
        #1 check("R8", 32'(mirror_horiz), 0);
        wr(15'h1001, 8'hFF); exp_mir = 1;
    endtask

    task automatic t_ignored;
        wr(15'h1000, 8'h00);
        wr(15'h2001, 8'h1A);
        wr(15'h3008, 8'h55);
        wr(15'h0001, 8'h09);
        wr(15'h4001, 8'h0C);
        wr(15'h1002, 8'h00);
        wr(15'h5000, 8'h44);
        sweep("R9");
    endtask

    task automatic t_passthru;
        ppu_addr = 14'h2000; #1;
        check("R10", 32'(chr_rom_addr), 32'h2000);
        ppu_addr = 14'h3F1E; #1;
        check("R10", 32'(chr_rom_addr), 32'h3F1E);
    endtask

    task automatic t_mask;
        wr(15'h2000, 8'hFF); exp_prg[1] = 8'hFF;
        cpu_addr = 15'h2000; #1;
        check("R5", 32'(prg_rom_addr), 32'({5'h1F, 13'h0}));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_prg_writes();
        t_slot3();
        t_chr_writes();
        t_mirror();
        t_ignored();
        t_passthru();
        t_mask();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule